// File: doc/BRIEF.md
# Reset Cause Recorder with Keyed Source Masking

This block sits beside a chip's reset generator. It watches seven reset request lines: power-on detect, watchdog timeout, temperature-sensor alarm, core lockup, software request, JTAG software request and JTAG-generated request. It decides which of them may reset the chip and raises a one-cycle-late qualified request. It also records which sources fired in a sticky status word that software reads back after the reset.

Software masks the watchdog and the temperature alarm through 4-bit key fields rather than single bits, so a stray single-bit upset cannot silently disable a safety reset. The lockup source has a plain enable bit. Status flags are write-one-to-clear. A separate warm-boot bit in the same word is plain read/write, so software can leave a note for itself across a warm reset. A single register port with a valid strobe, a write flag and a one-bit address reaches the control word (address 0) and the status word (address 1).

Top module: `rcause_top`

## Requirements
- R1: After the synchronous active-low reset, the control word reads 0x02A (watchdog key 0xA in bits [3:0], temperature key 0x2 in bits [7:4], lockup enable bit 8 clear), the status word reads 0 and the qualified request is low.
- R2: When any unmasked source is high at a clock edge, `rst_req` is high during the following cycle. It is low after any edge at which no unmasked source is high. Software, both JTAG sources and power-on are never masked.
- R3: Watchdog key 0x5 blocks the watchdog from raising `rst_req`. Key 0xA, and every code other than 0x5, lets it through.
- R4: Temperature key 0x5 blocks the temperature alarm: it raises no request and sets no flag. Every other code lets it through.
- R5: Core lockup raises a request and sets its flag only while control bit 8 is 1.
- R6: At each edge, every source that is allowed through sets its status bit (power-on 0, watchdog 1, temperature 2, lockup 3, software 4, JTAG software 5, JTAG generated 6). Several can be set at the same edge, and flags set earlier persist.
- R7: A write to the status word clears each flag whose data bit is 1 and leaves the others. A source that is active in the same cycle wins over the clear.
- R8: A watchdog event sets bit 1 even while the watchdog is masked. While the key is 0x5, writes cannot clear that bit. Only an unmasked clear or the hardware reset removes it.
- R9: A write-one-to-clear on the temperature flag has no effect while the temperature input is still high.
- R10: Status bit 7 is the warm-boot indication. A status write loads it with data bit 7. It is never cleared by writing 1 to a flag position, and a write with flag bits 0 loads it without touching any flag.
- R11: Power-on at an edge leaves the status word at exactly 0x001, clearing all other flags and the warm-boot bit, even against a same-cycle write.
- R12: A JTAG-generated request sets only bit 6, and a JTAG software request sets only bit 5.
- R13: Register writes take effect only when `reg_valid` and `reg_write` are both high. `reg_rdata` shows the control word for address 0 and the status word for address 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| src_por | input | 1 | Power-on detect request |
| src_wdog | input | 1 | Watchdog timeout request |
| src_temp | input | 1 | Temperature alarm (level until serviced) |
| src_lockup | input | 1 | Core lockup indication |
| src_sw | input | 1 | Software reset request |
| src_jtag_sw | input | 1 | JTAG software reset request |
| src_jtag_gen | input | 1 | JTAG-generated reset request |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 1 | 0 = control word, 1 = status word |
| reg_wdata | input | 9 | Write data |
| reg_rdata | output | 9 | Read data for the addressed word |
| rst_req | output | 1 | Qualified reset request |
| status | output | 9 | Status word (flags and warm-boot bit) |

## Verification
The hardest state to reach is a sticky flag that the block refuses to clear. The watchdog bit must be set while its key holds 0x5, and then a clear must be attempted before the key is changed. Likewise the temperature flag must be captured and a clear written while the alarm line is still held high. Directed sequences first program the key, fire the source, attempt the clear, then reopen the mask or drop the line and clear again. A long random phase then mixes sparse source pulses with random writes whose key fields are biased toward 0x5, 0xA, 0x2 and odd codes, against a bench model of the requirements.

// File: rtl/rcause_pkg.sv
`timescale 1ns/1ps
// rcause_pkg: shared widths, bit positions and key codes for the reset
// cause recorder. Assumes seven sources and 4-bit mask keys.
package rcause_pkg;
    localparam int KEY_W    = 4;
    localparam int N_SRC    = 7;
    localparam int CTRL_W   = 2 * KEY_W + 1;
    localparam int WARM_BIT = N_SRC;
    localparam int STAT_W   = N_SRC + 1;
    localparam int DATA_W   = (CTRL_W > STAT_W) ? CTRL_W : STAT_W;

    // Source positions inside the status word (software decodes these).
    localparam int IDX_POR  = 0;
    localparam int IDX_WDOG = 1;
    localparam int IDX_TEMP = 2;
    localparam int IDX_LOCK = 3;
    localparam int IDX_SW   = 4;
    localparam int IDX_JSW  = 5;
    localparam int IDX_JGEN = 6;

    localparam logic [KEY_W-1:0] KEY_WDOG_OPEN = 4'hA;
    localparam logic [KEY_W-1:0] KEY_TEMP_OPEN = 4'h2;
    localparam logic [KEY_W-1:0] KEY_MASKED    = 4'h5;

    typedef struct packed {
        logic             lockup_en;
        logic [KEY_W-1:0] temp_key;
        logic [KEY_W-1:0] wdog_key;
    } ctrl_t;

    localparam ctrl_t CTRL_DEFAULT = '{lockup_en: 1'b0,
                                       temp_key:  KEY_TEMP_OPEN,
                                       wdog_key:  KEY_WDOG_OPEN};

    // Only the exact masked code blocks a source; any other code is open.
    function automatic logic key_blocks(input logic [KEY_W-1:0] key);
        return key == KEY_MASKED;
    endfunction
endpackage

// File: rtl/rcause_ctrl.sv
`timescale 1ns/1ps
// rcause_ctrl: holds the mask keys and lockup enable.
// Assumes the write strobe is already qualified by the caller.
module rcause_ctrl
    import rcause_pkg::*;
#(
    parameter int CW = CTRL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [CW-1:0] wdata,
    output ctrl_t         ctrl_q
);
    // Control register: defaults on reset, full load on write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_DEFAULT;
        end else if (wr_en) begin
            ctrl_q <= ctrl_t'(wdata);
        end
    end
endmodule

// File: rtl/rcause_qual.sv
`timescale 1ns/1ps
// rcause_qual: decides which active sources may reset the chip and which
// set a flag. Purely combinational; a masked watchdog still flags.
module rcause_qual
    import rcause_pkg::*;
#(
    parameter int NS = N_SRC
) (
    input  logic [NS-1:0] src_vec,
    input  ctrl_t         ctrl,
    output logic [NS-1:0] qual_vec,
    output logic [NS-1:0] hit_vec,
    output logic          wdog_masked,
    output logic          temp_masked
);
    logic [NS-1:0] gate;

    // Per-source permission derived from the keys and the lockup enable.
    always_comb begin
        wdog_masked    = key_blocks(ctrl.wdog_key);
        temp_masked    = key_blocks(ctrl.temp_key);
        gate           = '1;
        gate[IDX_WDOG] = ~wdog_masked;
        gate[IDX_TEMP] = ~temp_masked;
        gate[IDX_LOCK] = ctrl.lockup_en;
    end

    // Qualified sources request reset; the watchdog records regardless.
    always_comb begin
        qual_vec          = src_vec & gate;
        hit_vec           = qual_vec;
        hit_vec[IDX_WDOG] = src_vec[IDX_WDOG];
    end
endmodule

// File: rtl/rcause_flags.sv
`timescale 1ns/1ps
// rcause_flags: sticky cause flags with write-one-to-clear and the
// warm-boot bit. Power-on overrides everything; set beats clear.
module rcause_flags
    import rcause_pkg::*;
#(
    parameter int NS = N_SRC
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NS-1:0] hit_vec,
    input  logic          por_now,
    input  logic          clr_wr,
    input  logic [NS:0]   wdata,
    input  logic          wdog_masked,
    input  logic          temp_active,
    output logic [NS-1:0] flags_q,
    output logic          warm_q
);
    logic [NS-1:0] clr_ok;
    logic [NS-1:0] clr_vec;

    // Which flags software may clear this cycle.
    always_comb begin
        clr_ok           = '1;
        clr_ok[IDX_WDOG] = ~wdog_masked;
        clr_ok[IDX_TEMP] = ~temp_active;
        clr_vec          = clr_wr ? (wdata[NS-1:0] & clr_ok) : '0;
    end

    // One sticky flag per source.
    for (genvar i = 0; i < NS; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flags_q[i] <= 1'b0;
            end else if (por_now) begin
                flags_q[i] <= (i == IDX_POR);
            end else begin
                flags_q[i] <= hit_vec[i] | (flags_q[i] & ~clr_vec[i]);
            end
        end
    end

    // Warm-boot indication: plain software bit, dropped on power-on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            warm_q <= 1'b0;
        end else if (por_now) begin
            warm_q <= 1'b0;
        end else if (clr_wr) begin
            warm_q <= wdata[NS];
        end
    end
endmodule

// File: rtl/rcause_top.sv
`timescale 1ns/1ps
// rcause_top: reset cause recorder. Gathers the sources, qualifies them,
// records flags and presents a two-word register port.
// Assumes all inputs are synchronous to clk.
module rcause_top
    import rcause_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_por,
    input  logic              src_wdog,
    input  logic              src_temp,
    input  logic              src_lockup,
    input  logic              src_sw,
    input  logic              src_jtag_sw,
    input  logic              src_jtag_gen,
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic              reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              rst_req,
    output logic [DATA_W-1:0] status
);
    logic [N_SRC-1:0] src_vec;
    logic [N_SRC-1:0] qual_vec;
    logic [N_SRC-1:0] hit_vec;
    logic [N_SRC-1:0] flags_q;
    logic             warm_q;
    logic             wdog_masked;
    logic             temp_masked;
    logic             ctrl_wr;
    logic             stat_wr;
    ctrl_t            ctrl_q;

    // Pack the sources in status-bit order and decode register writes.
    always_comb begin
        src_vec           = '0;
        src_vec[IDX_POR]  = src_por;
        src_vec[IDX_WDOG] = src_wdog;
        src_vec[IDX_TEMP] = src_temp;
        src_vec[IDX_LOCK] = src_lockup;
        src_vec[IDX_SW]   = src_sw;
        src_vec[IDX_JSW]  = src_jtag_sw;
        src_vec[IDX_JGEN] = src_jtag_gen;
        ctrl_wr           = reg_valid & reg_write & ~reg_addr;
        stat_wr           = reg_valid & reg_write &  reg_addr;
    end

    rcause_ctrl #(.CW(CTRL_W)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (ctrl_wr),
        .wdata  (reg_wdata[CTRL_W-1:0]),
        .ctrl_q (ctrl_q)
    );

    rcause_qual #(.NS(N_SRC)) u_qual (
        .src_vec     (src_vec),
        .ctrl        (ctrl_q),
        .qual_vec    (qual_vec),
        .hit_vec     (hit_vec),
        .wdog_masked (wdog_masked),
        .temp_masked (temp_masked)
    );

    rcause_flags #(.NS(N_SRC)) u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .hit_vec     (hit_vec),
        .por_now     (src_por),
        .clr_wr      (stat_wr),
        .wdata       (reg_wdata[N_SRC:0]),
        .wdog_masked (wdog_masked),
        .temp_active (src_temp),
        .flags_q     (flags_q),
        .warm_q      (warm_q)
    );

    // Qualified request, registered one cycle behind the sources.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req <= 1'b0;
        end else begin
            rst_req <= |qual_vec;
        end
    end

    // Assemble the status word and the read mux.
    always_comb begin
        status                  = '0;
        status[N_SRC-1:0]       = flags_q;
        status[WARM_BIT]        = warm_q;
        reg_rdata               = '0;
        if (reg_addr) begin
            reg_rdata = status;
        end else begin
            reg_rdata[CTRL_W-1:0] = ctrl_q;
        end
    end

    logic unused_temp_masked;
    assign unused_temp_masked = temp_masked;
endmodule

// File: rtl/rcause_chk.sv
`timescale 1ns/1ps
// rcause_chk: temporal properties of the reset cause recorder, bound to
// the top module. Assumes rst_n is low from time zero.
module rcause_chk
    import rcause_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              src_por,
    input logic              src_temp,
    input logic              src_sw,
    input logic              src_jtag_gen,
    input logic              wdog_masked,
    input logic              rst_req,
    input logic [DATA_W-1:0] status
);
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (status == '0 && !rst_req));

    p_sw_request_r2: assert property (@(posedge clk) disable iff (!rst_n)
        src_sw |=> rst_req);

    p_wdog_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (status[IDX_WDOG] && wdog_masked && !src_por) |=> status[IDX_WDOG]);

    p_temp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (status[IDX_TEMP] && src_temp && !src_por) |=> status[IDX_TEMP]);

    p_por_alone_r11: assert property (@(posedge clk) disable iff (!rst_n)
        src_por |=> (status == DATA_W'(1)));

    p_jtag_gen_flag_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (src_jtag_gen && !src_por) |=> status[IDX_JGEN]);
endmodule

bind rcause_top rcause_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .src_por      (src_por),
    .src_temp     (src_temp),
    .src_sw       (src_sw),
    .src_jtag_gen (src_jtag_gen),
    .wdog_masked  (wdog_masked),
    .rst_req      (rst_req),
    .status       (status)
);

// File: tb/tb_rcause_top.sv
`timescale 1ns/1ps
module tb_rcause_top;
    localparam int W = 9;
    localparam time HALF = 10ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [6:0] src = '0;
    logic reg_valid = 1'b0, reg_write = 1'b0, reg_addr = 1'b0;
    logic [W-1:0] reg_wdata = '0;
    logic [W-1:0] reg_rdata, status;
    logic rst_req;

    int tests = 0;
    int fails = 0;

    // Bench model state
    logic [8:0] m_ctrl = 9'h02A;
    logic [6:0] m_flags = '0;
    logic       m_warm = 1'b0;
    logic       m_req = 1'b0;

    always #HALF clk = ~clk;

    rcause_top dut (
        .clk(clk), .rst_n(rst_n),
        .src_por(src[0]), .src_wdog(src[1]), .src_temp(src[2]),
        .src_lockup(src[3]), .src_sw(src[4]), .src_jtag_sw(src[5]),
        .src_jtag_gen(src[6]),
        .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rst_req(rst_req), .status(status)
    );

    task automatic check(input string tag, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    // Next model state from the requirements, using pre-edge inputs.
    task automatic model_step();
        logic wm, tm;
        logic [6:0] gate, qual, hit, clr;
        logic swr, cwr;
        if (!rst_n) begin
            m_ctrl = 9'h02A; m_flags = '0; m_warm = 1'b0; m_req = 1'b0;
            return;
        end
        wm = (m_ctrl[3:0] == 4'h5);
        tm = (m_ctrl[7:4] == 4'h5);
        gate = 7'h7F; gate[1] = ~wm; gate[2] = ~tm; gate[3] = m_ctrl[8];
        qual = src & gate;
        hit = qual; hit[1] = src[1];
        swr = reg_valid & reg_write & reg_addr;
        cwr = reg_valid & reg_write & ~reg_addr;
        m_req = |qual;
        if (src[0]) begin
            m_flags = 7'h01; m_warm = 1'b0;
        end else begin
            clr = swr ? reg_wdata[6:0] : '0;
            clr[1] = clr[1] & ~wm;
            clr[2] = clr[2] & ~src[2];
            m_flags = hit | (m_flags & ~clr);
            if (swr) m_warm = reg_wdata[7];
        end
        if (cwr) m_ctrl = reg_wdata;
    endtask

    function automatic logic [W-1:0] exp_rd();
        return reg_addr ? {1'b0, m_warm, m_flags} : m_ctrl;
    endfunction

    task automatic cyc(input string tag);
        model_step();
        @(posedge clk);
        @(negedge clk);
        check(tag, "status", status, {1'b0, m_warm, m_flags});
        check(tag, "rst_req", {8'b0, rst_req}, {8'b0, m_req});
        check(tag, "rdata", reg_rdata, exp_rd());
    endtask

    task automatic step(input logic [6:0] s, input logic v, input logic w,
                        input logic a, input logic [W-1:0] d, input string tag);
        src = s; reg_valid = v; reg_write = w; reg_addr = a; reg_wdata = d;
        cyc(tag);
    endtask

    initial begin
        #(HALF * 2 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        cyc("R1"); cyc("R1");
        rst_n = 1'b1;
        step('0, 0, 0, 0, 0, "R1");
        check("R1", "ctrl default", reg_rdata, 9'h02A);
        check("R1", "status reset", status, 9'h000);

        // R2 / R6: software request
        step(7'h10, 0, 0, 1, 0, "R2");
        check("R2", "sw req", {8'b0, rst_req}, 9'h001);
        check("R6", "sw flag", status, 9'h010);
        step('0, 0, 0, 1, 0, "R2");
        check("R2", "req drops", {8'b0, rst_req}, 9'h000);
        // R7: W1C and zero bits keep
        step('0, 1, 1, 1, 9'h000, "R7");
        check("R7", "zero write keeps", status, 9'h010);
        step('0, 1, 1, 1, 9'h010, "R7");
        check("R7", "w1c", status, 9'h000);

        // R3 / R8: masked watchdog
        step('0, 1, 1, 0, 9'h025, "R3");
        step(7'h02, 0, 0, 1, 0, "R3");
        check("R3", "masked wdog no req", {8'b0, rst_req}, 9'h000);
        check("R8", "masked wdog flags", status, 9'h002);
        step('0, 1, 1, 1, 9'h002, "R8");
        check("R8", "sticky while masked", status, 9'h002);
        step('0, 1, 1, 0, 9'h027, "R3");
        step(7'h02, 0, 0, 1, 0, "R3");
        check("R3", "odd code open", {8'b0, rst_req}, 9'h001);
        step('0, 1, 1, 1, 9'h002, "R8");
        check("R8", "clear after unmask", status, 9'h000);

        // R4: masked temperature
        step('0, 1, 1, 0, 9'h05A, "R4");
        step(7'h04, 0, 0, 1, 0, "R4");
        check("R4", "masked temp", {rst_req, status[7:0]}, 9'h000);
        // R9: clear while alarm held
        step('0, 1, 1, 0, 9'h02A, "R4");
        step(7'h04, 0, 0, 1, 0, "R4");
        check("R4", "open temp req", {8'b0, rst_req}, 9'h001);
        step(7'h04, 1, 1, 1, 9'h004, "R9");
        check("R9", "held temp flag", status, 9'h004);
        step('0, 1, 1, 1, 9'h004, "R9");
        check("R9", "temp cleared", status, 9'h000);

        // R5: lockup enable
        step(7'h08, 0, 0, 1, 0, "R5");
        check("R5", "lockup off", {rst_req, status[7:0]}, 9'h000);
        step('0, 1, 1, 0, 9'h12A, "R5");
        step(7'h08, 0, 0, 1, 0, "R5");
        check("R5", "lockup on", {rst_req, status[7:0]}, 9'h108);

        // R12: JTAG flags distinct
        step('0, 1, 1, 1, 9'h07F, "R12");
        step(7'h40, 0, 0, 1, 0, "R12");
        check("R12", "jtag gen", status, 9'h040);
        step(7'h20, 0, 0, 1, 0, "R12");
        check("R12", "jtag sw", status, 9'h060);

        // R10: warm bit and set-beats-clear (R7)
        step('0, 1, 1, 1, 9'h080, "R10");
        check("R10", "warm set, flags kept", status, 9'h0E0);
        step(7'h10, 1, 1, 1, 9'h090, "R7");
        check("R7", "set beats clear", status, 9'h0F0);

        // R11: power-on wins over write
        step(7'h01, 1, 1, 1, 9'h0FE, "R11");
        check("R11", "por alone", status, 9'h001);

        // R13: no write without valid; address select
        step('0, 0, 1, 0, 9'h055, "R13");
        check("R13", "ctrl unchanged", reg_rdata, 9'h12A);
        step('0, 1, 0, 1, 9'h001, "R13");
        check("R13", "read is not write", reg_rdata, 9'h001);

        // Random phase (R2, R6, R7, R3, R4)
        void'($urandom(32'd1234));
        for (int i = 0; i < 4000; i++) begin
            logic [6:0] s;
            logic [W-1:0] d;
            for (int b = 0; b < 7; b++) s[b] = ($urandom % (b == 0 ? 64 : 12)) == 0;
            d = W'($urandom);
            if (($urandom % 2) == 0) begin
                case ($urandom % 4)
                    0: d[3:0] = 4'h5; 1: d[3:0] = 4'hA; default: ;
                endcase
                case ($urandom % 4)
                    0: d[7:4] = 4'h5; 1: d[7:4] = 4'h2; default: ;
                endcase
            end
            step(s, ($urandom % 4) == 0, ($urandom % 2) == 0, 1'($urandom), d, "R6");
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule